// File: doc/BRIEF.md
# Cache Line Fill Burst Sequencer

This block serves a cache on a miss. It takes the byte address that missed, clears the offset bits to find the aligned line that holds it, and sends the memory one burst request carrying that line base. The memory then returns the whole line as a stream of narrow device words, one word in each cycle that has the beat-valid strobe high. No further addresses are sent during the burst.

Inside the block, groups of adjacent device words are packed into wide units. The size of a group is the burst depth: 4 words of 16 bits make a 64-bit unit, and 8 words make a 128-bit unit. The units are collected in a staging buffer. The finished line is copied to the fill output in one step, together with its base address and a one-cycle done pulse. A line that is only partly received never appears on the output. Tag lookup, replacement policy and write-back belong to other blocks.

The defaults are a 16-byte line, 16-bit device words and a burst depth of 4. With these values a line takes 8 beats and is built from two 64-bit units.

Top module: `lf_burst_fill`

## Requirements
- R1: `miss_ready` is high when no fill is in progress. It is low from the cycle after a miss is accepted until the fill completes, and a `miss_valid` seen while it is low is ignored: no extra burst request is made and no base is changed.
- R2: Exactly one cycle after a miss is accepted (`miss_valid` and `miss_ready` high at a clock edge), `mem_req` is high for exactly one cycle. During that cycle `mem_addr` equals the miss address with its low log2(LINE_BYTES) bits cleared.
- R3: While `fill_done` is high, `fill_base` equals the accepted miss address with its low log2(LINE_BYTES) bits cleared. For example, 0x124A gives 0x1240.
- R4: A fill completes only after LINE_BYTES*8/DEV_W accepted beats (8 with the defaults). Beats are counted from the cycle after `mem_req`.
- R5: The beats arrive in increasing address order starting at the line base. Beat j of a fill appears in `fill_line` bits DEV_W*j+DEV_W-1 down to DEV_W*j. Each group of BURST_DEPTH beats forms one wide unit, with its lowest address in the least significant position.
- R6: `fill_done` is high for exactly one cycle: the cycle after the clock edge that samples the last beat.
- R7: `fill_line` changes only in a cycle where `fill_done` is high. While a fill is in progress it keeps the previous complete line.
- R8: `mem_beat_valid` pulses while no fill is collecting have no effect on `fill_done` or on the content of the next line.
- R9: A new miss can be accepted in the same cycle that `fill_done` is high.
- R10: Cycles with `mem_beat_valid` low in the middle of a burst stall the packing without losing or reordering words.
- R11: After reset, `miss_ready` is 1 and `mem_req`, `fill_done`, `fill_line` and `fill_base` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | ADDR_W | Byte address that missed |
| miss_ready | output | 1 | Block can accept a miss |
| mem_req | output | 1 | One-cycle burst request |
| mem_addr | output | ADDR_W | Aligned burst start address |
| mem_beat_valid | input | 1 | Device word present this cycle |
| mem_beat_data | input | DEV_W | Device word |
| fill_done | output | 1 | One-cycle pulse: a complete line is on `fill_line` |
| fill_base | output | ADDR_W | Base address of the completed line |
| fill_line | output | LINE_BYTES*8 | Completed line data |

## Verification
Two events can fall in the same cycle: the completion pulse of one fill and the acceptance of the next miss. The bench runs fills back to back. Each new `miss_valid` is raised in the cycle where `fill_done` is high. The bench then checks three things: the scoreboard still receives the earlier line and base intact, the new burst request appears one cycle later with the new aligned address, and the total count of burst requests equals the number of fills issued. A stray miss during a burst and stray beats while idle are mixed in, and the bench confirms that neither changes the result.

// File: rtl/lf_pkg.sv
package lf_pkg;
   typedef enum logic [1:0] {
      LF_IDLE = 2'd0,
      LF_REQ  = 2'd1,
      LF_FILL = 2'd2
   } lf_state_e;
endpackage

// File: rtl/lf_align.sv
module lf_align #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4
) (
   input  logic [ADDR_W-1:0] byte_addr,
   output logic [ADDR_W-1:0] line_addr
);
   generate
      if (OFF_W == 0) begin : g_no_offset
         assign line_addr = byte_addr;
      end else begin : g_clear_offset
         assign line_addr = {byte_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/lf_seq.sv
module lf_seq
   import lf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic miss_valid,
   input  logic line_last,
   output logic miss_ready,
   output logic accept,
   output logic req_pulse,
   output logic collecting
);
   lf_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         LF_IDLE: if (miss_valid) state_d = LF_REQ;
         LF_REQ:  state_d = LF_FILL;
         LF_FILL: if (line_last) state_d = LF_IDLE;
         default: state_d = LF_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= LF_IDLE;
      else        state_q <= state_d;
   end

   assign miss_ready = (state_q == LF_IDLE);
   assign accept     = miss_ready && miss_valid;
   assign req_pulse  = (state_q == LF_REQ);
   assign collecting = (state_q == LF_FILL);
endmodule

// File: rtl/lf_packer.sv
module lf_packer #(
   parameter int DEV_W  = 16,
   parameter int DEPTH  = 4,
   parameter int NUNITS = 2,
   localparam int UNIT_W = DEV_W * DEPTH,
   localparam int WIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int UIDX_W = (NUNITS > 1) ? $clog2(NUNITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              beat_valid,
   input  logic [DEV_W-1:0]  beat_data,
   output logic              unit_valid,
   output logic              unit_last,
   output logic [UIDX_W-1:0] unit_idx,
   output logic [UNIT_W-1:0] unit_data
);
   logic [WIDX_W-1:0] widx_q;
   logic [UIDX_W-1:0] uidx_q;
   logic              grp_end;

   assign grp_end = beat_valid && (widx_q == WIDX_W'(DEPTH-1));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         widx_q <= '0;
         uidx_q <= '0;
      end else if (beat_valid) begin
         if (grp_end) begin
            widx_q <= '0;
            uidx_q <= uidx_q + 1'b1;
         end else begin
            widx_q <= widx_q + 1'b1;
         end
      end
   end

   genvar k;
   generate
      for (k = 0; k < DEPTH-1; k++) begin : g_word
         logic [DEV_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               word_q <= '0;
            else if (beat_valid && (widx_q == WIDX_W'(k)))
               word_q <= beat_data;
         end
         assign unit_data[DEV_W*k +: DEV_W] = word_q;
      end
   endgenerate

   assign unit_data[DEV_W*(DEPTH-1) +: DEV_W] = beat_data;
   assign unit_valid = grp_end;
   assign unit_idx   = uidx_q;
   assign unit_last  = grp_end && (uidx_q == UIDX_W'(NUNITS-1));
endmodule

// File: rtl/lf_line_asm.sv
module lf_line_asm #(
   parameter int UNIT_W = 64,
   parameter int NUNITS = 2,
   localparam int LINE_W = UNIT_W * NUNITS,
   localparam int UIDX_W = (NUNITS > 1) ? $clog2(NUNITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unit_valid,
   input  logic              unit_last,
   input  logic [UIDX_W-1:0] unit_idx,
   input  logic [UNIT_W-1:0] unit_data,
   output logic [LINE_W-1:0] line,
   output logic              done
);
   logic [LINE_W-1:0] assembled;

   genvar u;
   generate
      if (NUNITS == 1) begin : g_single
         assign assembled = unit_data;
      end else begin : g_multi
         for (u = 0; u < NUNITS-1; u++) begin : g_stage
            logic [UNIT_W-1:0] stage_q;
            always_ff @(posedge clk) begin
               if (!rst_n)
                  stage_q <= '0;
               else if (unit_valid && (unit_idx == UIDX_W'(u)))
                  stage_q <= unit_data;
            end
            assign assembled[UNIT_W*u +: UNIT_W] = stage_q;
         end
         assign assembled[UNIT_W*(NUNITS-1) +: UNIT_W] = unit_data;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line <= '0;
         done <= 1'b0;
      end else begin
         done <= unit_last;
         if (unit_last) line <= assembled;
      end
   end
endmodule

// File: rtl/lf_burst_fill.sv
module lf_burst_fill #(
   parameter int ADDR_W      = 32,
   parameter int LINE_BYTES  = 16,
   parameter int DEV_W       = 16,
   parameter int BURST_DEPTH = 4,
   localparam int LINE_BITS  = LINE_BYTES * 8,
   localparam int OFF_W      = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 0,
   localparam int UNIT_W     = DEV_W * BURST_DEPTH,
   localparam int NUNITS     = LINE_BITS / UNIT_W,
   localparam int UIDX_W     = (NUNITS > 1) ? $clog2(NUNITS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 miss_valid,
   input  logic [ADDR_W-1:0]    miss_addr,
   output logic                 miss_ready,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 mem_beat_valid,
   input  logic [DEV_W-1:0]     mem_beat_data,
   output logic                 fill_done,
   output logic [ADDR_W-1:0]    fill_base,
   output logic [LINE_BITS-1:0] fill_line
);
   generate
      if ((LINE_BYTES < 1) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
      if (BURST_DEPTH < 2) begin : g_bad_depth
         $error("BURST_DEPTH must be at least 2");
      end
      if ((NUNITS < 1) || ((LINE_BITS % UNIT_W) != 0)) begin : g_bad_unit
         $error("line width must be a whole number of packed units");
      end
      if (OFF_W >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W too small for LINE_BYTES");
      end
   endgenerate

   logic              accept, collecting, line_last;
   logic              beat_ok, unit_valid;
   logic [UIDX_W-1:0] unit_idx;
   logic [UNIT_W-1:0] unit_data;
   logic [ADDR_W-1:0] aligned, base_q;

   lf_align #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_align (
      .byte_addr (miss_addr),
      .line_addr (aligned)
   );

   lf_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .line_last  (line_last),
      .miss_ready (miss_ready),
      .accept     (accept),
      .req_pulse  (mem_req),
      .collecting (collecting)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      base_q <= '0;
      else if (accept) base_q <= aligned;
   end

   assign beat_ok = mem_beat_valid && collecting;

   lf_packer #(.DEV_W(DEV_W), .DEPTH(BURST_DEPTH), .NUNITS(NUNITS)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .beat_valid (beat_ok),
      .beat_data  (mem_beat_data),
      .unit_valid (unit_valid),
      .unit_last  (line_last),
      .unit_idx   (unit_idx),
      .unit_data  (unit_data)
   );

   lf_line_asm #(.UNIT_W(UNIT_W), .NUNITS(NUNITS)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .unit_valid (unit_valid),
      .unit_last  (line_last),
      .unit_idx   (unit_idx),
      .unit_data  (unit_data),
      .line       (fill_line),
      .done       (fill_done)
   );

   assign mem_addr  = base_q;
   assign fill_base = base_q;
endmodule

// File: rtl/lf_burst_fill_chk.sv
module lf_burst_fill_chk #(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 4,
   parameter int NBEATS    = 8,
   parameter int LINE_BITS = 128
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 miss_valid,
   input logic                 miss_ready,
   input logic                 mem_req,
   input logic [ADDR_W-1:0]    mem_addr,
   input logic                 mem_beat_valid,
   input logic                 fill_done,
   input logic [ADDR_W-1:0]    fill_base,
   input logic [LINE_BITS-1:0] fill_line
);
   localparam int CNT_W = $clog2(NBEATS + 1) + 1;
   logic             open_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (mem_req) begin
         open_q <= 1'b1;
         cnt_q  <= '0;
      end else if (open_q && mem_beat_valid) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CNT_W'(NBEATS-1)) open_q <= 1'b0;
      end
   end

   a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !miss_ready);
   a_r2_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> mem_req);
   a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   a_r2_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFF_W-1:0] == '0));
   a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> (fill_base[OFF_W-1:0] == '0));
   a_r4_beat_count: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> (cnt_q == CNT_W'(NBEATS)));
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> !fill_done);
   a_r7_line_held: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_done |-> $stable(fill_line));
   a_r9_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> miss_ready);
endmodule

bind lf_burst_fill lf_burst_fill_chk #(
   .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NBEATS(LINE_BITS / DEV_W), .LINE_BITS(LINE_BITS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .miss_valid     (miss_valid),
   .miss_ready     (miss_ready),
   .mem_req        (mem_req),
   .mem_addr       (mem_addr),
   .mem_beat_valid (mem_beat_valid),
   .fill_done      (fill_done),
   .fill_base      (fill_base),
   .fill_line      (fill_line)
);

// File: tb/test_lf_burst_fill.sv
module test_lf_burst_fill;
   localparam int AW = 32;
   localparam int DW = 16;
   localparam int LB = 128;
   localparam int NB = LB / DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [AW-1:0] miss_addr = '0;
   logic          miss_ready;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_beat_valid = 1'b0;
   logic [DW-1:0] mem_beat_data = '0;
   logic          fill_done;
   logic [AW-1:0] fill_base;
   logic [LB-1:0] fill_line;

   int n_chk = 0;
   int n_bad = 0;
   int n_fills = 0;
   int n_reqs = 0;
   bit finished = 1'b0;

   logic [AW-1:0] q_base[$];
   logic [LB-1:0] q_line[$];

   always #4 clk = ~clk;

   lf_burst_fill i_lf_burst_fill (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
      .miss_ready(miss_ready), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
      .fill_done(fill_done), .fill_base(fill_base), .fill_line(fill_line)
   );

   task automatic chk(input string req, input logic [LB-1:0] act, input logic [LB-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a, input int j);
      return DW'(a[15:0] ^ (16'h3C5A + 16'(j) * 16'h0911));
   endfunction

   task automatic do_fill(input logic [AW-1:0] addr, input bit gaps, input bit stray_miss);
      logic [AW-1:0] base;
      logic [LB-1:0] line;
      base = {addr[AW-1:4], 4'h0};
      for (int j = 0; j < NB; j++) line[DW*j +: DW] = word_of(addr, j);
      q_base.push_back(base);
      q_line.push_back(line);
      n_fills++;
      while (!miss_ready) @(negedge clk);
      miss_valid = 1'b1;
      miss_addr  = addr;
      @(negedge clk);
      miss_valid = 1'b0;
      chk("R2 req", LB'(mem_req), LB'(1));
      chk("R2 addr", LB'(mem_addr), LB'(base));
      chk("R1 busy", LB'(miss_ready), LB'(0));
      @(negedge clk);
      for (int j = 0; j < NB; j++) begin
         mem_beat_valid = 1'b1;
         mem_beat_data  = word_of(addr, j);
         chk("R4 no early done", LB'(fill_done), LB'(0));
         chk("R1 busy", LB'(miss_ready), LB'(0));
         if (stray_miss && j == 2) begin
            miss_valid = 1'b1;
            miss_addr  = addr ^ 32'h0000_0100;
         end
         @(negedge clk);
         miss_valid = 1'b0;
         if (gaps) begin
            mem_beat_valid = 1'b0;
            mem_beat_data  = 16'hDEAD;
            @(negedge clk);
         end
      end
      mem_beat_valid = 1'b0;
   endtask

   // monitor / scoreboard
   initial begin
      logic [LB-1:0] cur_line;
      bit prev_done;
      cur_line  = '0;
      prev_done = 1'b0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (mem_req) n_reqs++;
         if (prev_done) chk("R6 one cycle", LB'(fill_done), LB'(0));
         if (fill_done) begin
            if (q_base.size() == 0) begin
               chk("R4 unexpected done", LB'(1), LB'(0));
            end else begin
               chk("R3 base", LB'(fill_base), LB'(q_base.pop_front()));
               chk("R5 R10 line", fill_line, q_line.pop_front());
               chk("R9 ready at done", LB'(miss_ready), LB'(1));
            end
            cur_line = fill_line;
         end else if (fill_line !== cur_line) begin
            chk("R7 line held", fill_line, cur_line);
         end
         prev_done = fill_done;
      end
   end

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 ready", LB'(miss_ready), LB'(1));
      chk("R11 req", LB'(mem_req), LB'(0));
      chk("R11 done", LB'(fill_done), LB'(0));
      chk("R11 line", fill_line, LB'(0));
      chk("R11 base", LB'(fill_base), LB'(0));
      rst_n = 1'b1;
      @(negedge clk);
      // R8: stray beats while idle
      for (int j = 0; j < 5; j++) begin
         mem_beat_valid = 1'b1;
         mem_beat_data  = 16'hBEEF + 16'(j);
         @(negedge clk);
         chk("R8 idle beats no done", LB'(fill_done), LB'(0));
      end
      mem_beat_valid = 1'b0;
      chk("R8 idle beats line", fill_line, LB'(0));
      do_fill(32'h0000_124A, 1'b0, 1'b0);          // R3 example, R5
      do_fill(32'h0000_0007, 1'b1, 1'b0);          // R9 back to back, R10 gaps
      do_fill(32'hFFFF_FFFF, 1'b0, 1'b1);          // R1 stray miss
      do_fill(32'h8000_0010, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++)
         do_fill(32'h1357_9BDF * (i + 3), (i % 2) == 1, 1'b0);
      repeat (4) @(negedge clk);
      chk("R1 R9 request count", LB'(n_reqs), LB'(n_fills));
      chk("R4 all lines seen", LB'(q_base.size()), LB'(0));
      chk("R1 idle ready", LB'(miss_ready), LB'(1));
      summary();
   end
endmodule